// File: doc/BRIEF.md
# PCI Target Claim Decoder

This block sits on the target side of a 32-bit PCI bus and decides, one transaction at a time, whether the device owns the cycle. In the address/command phase it classifies the command nibble on C/BE#. I/O commands are compared against three programmable base windows, one per function. Configuration commands are qualified by IDSEL, by a type-0 address and by the function-number field. Memory, interrupt-acknowledge, special, dual-address and reserved commands are always left alone, so the master sees a master abort.

A claimed cycle is answered on DEVSEL# with medium timing: two clocks after the address edge. When the `fastDecode` input is high during the address phase, DEVSEL# comes one clock earlier. In the data phase the byte enables are judged. I/O accesses of three or four bytes end in a target abort. Configuration accesses complete when their enables form one contiguous run. A one-hot function select and a single-cycle claim strobe tell the rest of the device which function owns the transaction.

Top module: `pci_claim_decoder`

## Requirements
- R1: Commands 0010 and 0011 (I/O read/write) are claimed only when AD[31:3] equals bits [31:3] of one of the three base words. Commands 0000, 0001, 0100, 0101, 0110, 0111, 1000, 1001, 1100, 1101, 1110 and 1111 are never claimed. Every command code here is the value on C/BE# in the address phase.
- R2: Commands 1010 and 1011 (configuration read/write) are claimed only when all three of these hold in the address phase: IDSEL is high, AD[1:0] is 00, and the function number AD[10:8] is 0, 1 or 2.
- R3: With `fastDecode` low in the address phase, DEVSEL# of a claimed cycle is first low in the second clock after the address edge.
- R4: With `fastDecode` high in the address phase, DEVSEL# of a claimed cycle is first low in the clock directly after the address edge.
- R5: `funcSel` is one-hot or zero. For I/O, bit i marks base window i (bits [31:0] of `ioBase` are window 0, the next 32 bits window 1, the top 32 bits window 2), and the lowest index wins on overlap. For configuration, bit n marks function number n.
- R6: `claimStrobe` is high for exactly one cycle per claimed transaction, in the first cycle DEVSEL# is low. It never pulses for an unclaimed cycle.
- R7: In an I/O data phase, three or four enabled bytes (zeros on C/BE#) cause a target abort: STOP# low with DEVSEL# high and no TRDY#. One or two enabled bytes complete with TRDY#.
- R8: In a configuration data phase, any pattern whose enabled bytes form one contiguous run completes with TRDY#. A pattern with a gap (for example C/BE# = 1010) is target-aborted.
- R9: TRDY# is low only while DEVSEL# is low, and the block lets go of DEVSEL# after the final data transfer.
- R10: A clock edge with FRAME# and IRDY# both high returns the block to idle. In the following cycle DEVSEL#, TRDY# and STOP# are high and `funcSel` is zero.
- R11: For a cycle that is not claimed, DEVSEL#, TRDY# and STOP# stay high for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frameN | input | 1 | FRAME#, active low |
| irdyN | input | 1 | IRDY#, active low |
| ad | input | 32 | Address/data bus |
| cbeN | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| idsel | input | 1 | Configuration chip select |
| fastDecode | input | 1 | Requests fast DEVSEL# timing when high in the address phase |
| ioBase | input | 96 | Three 32-bit I/O base words, window 0 in the low bits |
| devselN | output | 1 | DEVSEL#, active low |
| trdyN | output | 1 | TRDY#, active low |
| stopN | output | 1 | STOP#, active low |
| funcSel | output | 3 | One-hot owning function |
| claimStrobe | output | 1 | One-cycle pulse when the claim is signalled |

## Verification
On the fast path, the first DEVSEL# cycle, which carries the claim strobe, is the same cycle in which the data-phase byte enables are judged. The claim and the width check therefore meet in one clock. The bench provokes this with fast-decode I/O accesses carrying 24-bit and 32-bit enables. It expects DEVSEL# low for exactly that one cycle with the strobe, then STOP# low with DEVSEL# released and no TRDY#. A legal fast access must instead move straight to TRDY#. The same enables under medium timing act as a control case in which the two events fall a cycle apart.

// File: rtl/pciclaim_pkg.sv
package pciclaim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_XFER,
    ST_ABORT,
    ST_BUSY
  } claimState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic clear;
  } ctrlStrobes_t;

  // decode results from datapath to control
  typedef struct packed {
    logic hit;
    logic beLegal;
  } decodeInfo_t;

  localparam logic [2:0] CMD_IO_HI  = 3'b001;
  localparam logic [2:0] CMD_CFG_HI = 3'b101;

endpackage

// File: rtl/claim_datapath.sv
module claim_datapath
  import pciclaim_pkg::*;
#(
  parameter int NUM_FUNC      = 3,
  parameter int ADDR_W        = 32,
  parameter int WIN_BITS      = 3,
  parameter int FUNC_LSB      = 8,
  parameter int FUNC_W        = 3,
  parameter int IO_MAX_BYTES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          ad,
  input  logic [ADDR_W/8-1:0]        cbeN,
  input  logic                       idsel,
  input  logic [NUM_FUNC*ADDR_W-1:0] ioBase,
  input  ctrlStrobes_t               strobes,
  output decodeInfo_t                info,
  output logic [NUM_FUNC-1:0]        funcSel
);

  localparam int BE_W  = ADDR_W / 8;
  localparam int CMP_W = ADDR_W - WIN_BITS;

  logic              isIoCmd;
  logic              isCfgCmd;
  logic [NUM_FUNC-1:0] winMatch;
  logic [NUM_FUNC-1:0] ioSel;
  logic [NUM_FUNC-1:0] cfgSel;
  logic [NUM_FUNC-1:0] nextSel;
  logic [FUNC_W-1:0] cfgFunc;
  logic              ioOk;
  logic              cfgOk;
  logic              kindIoQ;
  logic [NUM_FUNC-1:0] selQ;
  logic [BE_W-1:0]   byteEn;
  logic [BE_W-1:0]   fillLow;
  logic              contiguous;
  logic              unusedBits;

  assign isIoCmd  = (cbeN[3:1] == CMD_IO_HI);
  assign isCfgCmd = (cbeN[3:1] == CMD_CFG_HI);
  assign cfgFunc  = ad[FUNC_LSB +: FUNC_W];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FUNC; gi++) begin : g_win
      assign winMatch[gi] = (ad[ADDR_W-1:WIN_BITS] == ioBase[gi*ADDR_W+WIN_BITS +: CMP_W]);
      assign cfgSel[gi]   = (cfgFunc == FUNC_W'(gi));
    end
  endgenerate

  // lowest-numbered window wins on overlap
  always_comb begin
    logic found;
    found = 1'b0;
    ioSel = '0;
    for (int i = 0; i < NUM_FUNC; i++) begin
      if (winMatch[i] && !found) begin
        ioSel[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign ioOk    = isIoCmd && (|ioSel);
  assign cfgOk   = isCfgCmd && idsel && (ad[1:0] == 2'b00) && (|cfgSel);
  assign nextSel = ioOk ? ioSel : (cfgOk ? cfgSel : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ    <= '0;
      kindIoQ <= 1'b0;
    end else if (strobes.clear) begin
      selQ    <= '0;
      kindIoQ <= 1'b0;
    end else if (strobes.latch) begin
      selQ    <= nextSel;
      kindIoQ <= isIoCmd;
    end
  end

  // byte enable legality, judged on live C/BE# in the data phase
  assign byteEn     = ~cbeN;
  assign fillLow    = byteEn | (byteEn - BE_W'(1));
  assign contiguous = ((fillLow & (fillLow + BE_W'(1))) == '0);

  always_comb begin
    info.hit = ioOk || cfgOk;
    if (kindIoQ)
      info.beLegal = ($countones(byteEn) <= IO_MAX_BYTES);
    else
      info.beLegal = contiguous;
  end

  assign funcSel    = selQ;
  assign unusedBits = ^{ad, ioBase};

endmodule

// File: rtl/claim_control.sv
module claim_control
  import pciclaim_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frameN,
  input  logic         irdyN,
  input  logic         fastDecode,
  input  decodeInfo_t  info,
  output ctrlStrobes_t strobes,
  output logic         devselN,
  output logic         trdyN,
  output logic         stopN,
  output logic         claimStrobe
);

  claimState_t state;
  claimState_t nxt;
  logic        busIdle;

  assign busIdle = frameN && irdyN;

  always_comb begin
    nxt     = state;
    strobes = '0;
    case (state)
      ST_IDLE: begin
        if (!frameN) begin
          strobes.latch = 1'b1;
          if (info.hit) nxt = fastDecode ? ST_DATA : ST_WAIT;
          else          nxt = ST_BUSY;
        end
      end
      ST_WAIT:  nxt = busIdle ? ST_IDLE : ST_DATA;
      ST_DATA: begin
        if (busIdle)     nxt = ST_IDLE;
        else if (!irdyN) nxt = info.beLegal ? ST_XFER : ST_ABORT;
      end
      ST_XFER: begin
        if (busIdle)     nxt = ST_IDLE;
        else if (!irdyN) nxt = frameN ? ST_IDLE : ST_DATA;
      end
      ST_ABORT, ST_BUSY: begin
        if (busIdle) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    strobes.clear = (nxt == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      devselN     <= 1'b1;
      trdyN       <= 1'b1;
      stopN       <= 1'b1;
      claimStrobe <= 1'b0;
    end else begin
      state       <= nxt;
      devselN     <= !((nxt == ST_DATA) || (nxt == ST_XFER));
      trdyN       <= !(nxt == ST_XFER);
      stopN       <= !(nxt == ST_ABORT);
      claimStrobe <= (nxt == ST_DATA) && ((state == ST_IDLE) || (state == ST_WAIT));
    end
  end

endmodule

// File: rtl/pci_claim_decoder.sv
module pci_claim_decoder
  import pciclaim_pkg::*;
#(
  parameter int NUM_FUNC = 3,
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frameN,
  input  logic                       irdyN,
  input  logic [ADDR_W-1:0]          ad,
  input  logic [ADDR_W/8-1:0]        cbeN,
  input  logic                       idsel,
  input  logic                       fastDecode,
  input  logic [NUM_FUNC*ADDR_W-1:0] ioBase,
  output logic                       devselN,
  output logic                       trdyN,
  output logic                       stopN,
  output logic [NUM_FUNC-1:0]        funcSel,
  output logic                       claimStrobe
);

  ctrlStrobes_t strobes;
  decodeInfo_t  info;

  claim_datapath #(
    .NUM_FUNC(NUM_FUNC),
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ad     (ad),
    .cbeN   (cbeN),
    .idsel  (idsel),
    .ioBase (ioBase),
    .strobes(strobes),
    .info   (info),
    .funcSel(funcSel)
  );

  claim_control u_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameN     (frameN),
    .irdyN      (irdyN),
    .fastDecode (fastDecode),
    .info       (info),
    .strobes    (strobes),
    .devselN    (devselN),
    .trdyN      (trdyN),
    .stopN      (stopN),
    .claimStrobe(claimStrobe)
  );

endmodule

// File: rtl/claim_checker.sv
module claim_checker #(
  parameter int NUM_FUNC = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frameN,
  input logic                irdyN,
  input logic [3:0]          cbeN,
  input logic                fastDecode,
  input logic                devselN,
  input logic                trdyN,
  input logic                stopN,
  input logic [NUM_FUNC-1:0] funcSel,
  input logic                claimStrobe
);

  logic busyQ;
  logic addrPhase;
  logic claimableCmd;

  assign addrPhase    = !frameN && !busyQ;
  assign claimableCmd = (cbeN[3:1] == 3'b001) || (cbeN[3:1] == 3'b101);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busyQ <= 1'b0;
    else if (addrPhase)        busyQ <= 1'b1;
    else if (frameN && irdyN)  busyQ <= 1'b0;
  end

  a_r1_other_cmds_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (addrPhase && !claimableCmd) |=> devselN ##1 devselN);

  a_r3_medium_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (addrPhase && !fastDecode) |=> devselN);

  a_r5_funcsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(funcSel));

  a_r6_strobe_on_first_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    claimStrobe |-> (!devselN && $past(devselN)));

  a_r7_abort_releases_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    !stopN |-> devselN);

  a_r9_trdy_within_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    !trdyN |-> !devselN);

  a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frameN && irdyN) |=> (devselN && trdyN && stopN && (funcSel == '0)));

endmodule

bind pci_claim_decoder claim_checker #(.NUM_FUNC(NUM_FUNC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frameN     (frameN),
  .irdyN      (irdyN),
  .cbeN       (cbeN),
  .fastDecode (fastDecode),
  .devselN    (devselN),
  .trdyN      (trdyN),
  .stopN      (stopN),
  .funcSel    (funcSel),
  .claimStrobe(claimStrobe)
);

// File: tb/pci_claim_decoder_tb.sv
`timescale 1ns/1ps
module pci_claim_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbeN = 4'hF;
  logic        idsel = 1'b0;
  logic        fastDecode = 1'b0;
  logic [31:0] base0 = 32'h0000_1000;
  logic [31:0] base1 = 32'h0000_2040;
  logic [31:0] base2 = 32'h0000_3F08;
  logic [95:0] ioBase;
  logic        devselN, trdyN, stopN, claimStrobe;
  logic [2:0]  funcSel;

  assign ioBase = {base2, base1, base0};

  always #2.5 clk = ~clk;

  pci_claim_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .frameN(frameN), .irdyN(irdyN), .ad(ad),
    .cbeN(cbeN), .idsel(idsel), .fastDecode(fastDecode), .ioBase(ioBase),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .funcSel(funcSel),
    .claimStrobe(claimStrobe)
  );

  typedef struct {
    int       delay;   // cycles from address edge to first DEVSEL#, 0 = never
    logic [2:0] func;
    int       outcome; // 0 none, 1 transfer, 2 target abort
    string    tag;
  } exp_t;

  exp_t expQ[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit contigRun(input logic [3:0] en);
    int first = -1;
    int last  = -1;
    for (int i = 0; i < 4; i++) if (en[i]) begin
      if (first < 0) first = i;
      last = i;
    end
    if (first < 0) return 1'b1;
    for (int i = first; i <= last; i++) if (!en[i]) return 1'b0;
    return 1'b1;
  endfunction

  // expected result from the requirements
  function automatic exp_t model(input logic [3:0] cmd, input logic [31:0] addr,
                                 input logic sel, input logic [3:0] be,
                                 input logic fast, input string tag);
    exp_t e;
    logic [31:0] b [3];
    logic isIo = 1'b0;
    logic [3:0] en = ~be;
    bit legal;
    b[0] = base0; b[1] = base1; b[2] = base2;
    e.func = 3'b000; e.tag = tag;
    if (cmd == 4'b0010 || cmd == 4'b0011) begin                       // R1
      isIo = 1'b1;
      for (int i = 0; i < 3; i++)
        if (e.func == 3'b000 && addr[31:3] == b[i][31:3]) e.func = 3'(1 << i);
    end else if ((cmd == 4'b1010 || cmd == 4'b1011) && sel &&          // R2
                 addr[1:0] == 2'b00 && addr[10:8] < 3'd3) begin
      e.func = 3'(1 << addr[10:8]);
    end
    if (e.func == 3'b000) begin
      e.delay = 0; e.outcome = 0;
    end else begin
      e.delay = fast ? 1 : 2;                                          // R3 R4
      legal   = isIo ? ($countones(en) <= 2) : contigRun(en);          // R7 R8
      e.outcome = legal ? 1 : 2;
    end
    return e;
  endfunction

  task automatic doTx(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                      input logic [3:0] be, input logic fast, input string tag);
    bit gotT = 0;
    bit gotS = 0;
    expQ.push_back(model(cmd, addr, sel, be, fast, tag));
    @(negedge clk);
    frameN = 1'b0; ad = addr; cbeN = cmd; idsel = sel; fastDecode = fast;
    @(negedge clk);
    frameN = 1'b1; irdyN = 1'b0; cbeN = be; ad = 32'hA5A5_0000; idsel = 1'b0; fastDecode = 1'b0;
    for (int k = 0; k < 6 && !gotT && !gotS; k++) begin
      @(posedge clk); #1;
      if (!trdyN) gotT = 1;
      if (!stopN) gotS = 1;
    end
    if (gotT) @(posedge clk);
    @(negedge clk);
    irdyN = 1'b1; cbeN = 4'hF;
    repeat (3) @(negedge clk);
  endtask

  // monitor: follows each transaction at the ports and compares against the queue
  bit         active = 0;
  int         cyc, delay, strobeCnt, outc;
  logic [2:0] funcSeen;
  bit         strobeFirst, stopDevOk;

  initial forever begin
    @(posedge clk); #2;
    if (rst_n) begin
      if (!active && !frameN) begin
        active = 1; cyc = 0; delay = 0; strobeCnt = 0; outc = 0;
        funcSeen = 3'b000; strobeFirst = 0; stopDevOk = 1;
      end
      if (active) begin
        cyc++;
        if (claimStrobe) strobeCnt++;
        if (!devselN && delay == 0) begin
          delay = cyc; funcSeen = funcSel; strobeFirst = claimStrobe;
        end
        if (!trdyN) begin
          outc = 1;
          chk(!devselN, "R9 trdy without devsel", devselN, 0);
        end
        if (!stopN) begin
          outc = 2;
          if (!devselN) stopDevOk = 0;
        end
        if (frameN && irdyN) begin
          exp_t e;
          active = 0;
          if (expQ.size() == 0) begin
            chk(0, "R11 unexpected transaction", 1, 0);
          end else begin
            e = expQ.pop_front();
            if (e.outcome == 0) begin
              chk(delay == 0, {"R11 devsel on unclaimed ", e.tag}, delay, 0);
              chk(outc == 0,  {"R11 response on unclaimed ", e.tag}, outc, 0);
              chk(strobeCnt == 0, {"R6 strobe on unclaimed ", e.tag}, strobeCnt, 0);
            end else begin
              chk(delay == e.delay, {(e.delay == 1) ? "R4 fast timing " : "R3 medium timing ", e.tag},
                  delay, e.delay);
              chk(funcSeen == e.func, {"R5 funcSel ", e.tag}, funcSeen, e.func);
              chk(strobeCnt == 1 && strobeFirst, {"R6 strobe ", e.tag}, strobeCnt, 1);
              chk(outc == e.outcome, {(e.outcome == 2) ? "R7 R8 abort " : "R7 R8 transfer ", e.tag},
                  outc, e.outcome);
              if (outc == 2) chk(stopDevOk, {"R7 devsel during stop ", e.tag}, 0, 1);
            end
            chk(devselN && trdyN && stopN && funcSel == 3'b000, {"R10 release ", e.tag},
                {devselN, trdyN, stopN, funcSel}, 6'b111000);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(devselN && trdyN && stopN && funcSel == 3'b000 && !claimStrobe, "R10 reset state",
        {devselN, trdyN, stopN}, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // I/O windows (R1, R3, R4, R5, R7)
    doTx(4'b0010, 32'h0000_1004, 0, 4'b1110, 0, "io rd win0 byte medium");
    doTx(4'b0011, 32'h0000_3F0C, 0, 4'b1100, 1, "io wr win2 word fast");
    doTx(4'b0010, 32'h0000_2046, 0, 4'b0111, 0, "io rd win1 byte3");
    doTx(4'b0010, 32'h0000_2040, 0, 4'b0000, 0, "io rd win1 dword abort");
    doTx(4'b0011, 32'h0000_1000, 0, 4'b1000, 1, "io wr win0 tribyte fast abort");
    doTx(4'b0011, 32'h0000_3F08, 0, 4'b0000, 1, "io wr win2 dword fast abort");
    doTx(4'b0010, 32'h0000_1008, 0, 4'b1110, 0, "io miss just above win0");
    doTx(4'b0011, 32'h0000_5000, 1, 4'b1110, 1, "io miss");

    // configuration (R2, R8)
    doTx(4'b1010, 32'h0000_0004, 1, 4'b0000, 0, "cfg rd f0 dword");
    doTx(4'b1011, 32'h0000_0210, 1, 4'b1001, 1, "cfg wr f2 mid word fast");
    doTx(4'b1010, 32'h0000_0108, 1, 4'b1000, 0, "cfg rd f1 tribyte");
    doTx(4'b1011, 32'h0000_0100, 1, 4'b1010, 0, "cfg wr f1 gap abort");
    doTx(4'b1010, 32'h0000_0000, 0, 4'b0000, 0, "cfg idsel low");
    doTx(4'b1010, 32'h0000_0500, 1, 4'b0000, 0, "cfg func5");
    doTx(4'b1011, 32'h0000_0001, 1, 4'b0000, 1, "cfg type1");

    // never-claimed commands at an address inside window 0 (R1)
    doTx(4'b0110, 32'h0000_1000, 1, 4'b0000, 1, "mem rd");
    doTx(4'b0111, 32'h0000_1000, 1, 4'b0000, 0, "mem wr");
    doTx(4'b1101, 32'h0000_1000, 1, 4'b0000, 1, "dual addr");
    doTx(4'b0000, 32'h0000_1000, 1, 4'b0000, 0, "int ack");
    doTx(4'b0001, 32'h0000_1000, 1, 4'b0000, 0, "special");
    doTx(4'b1000, 32'h0000_1000, 1, 4'b0000, 0, "reserved 1000");
    doTx(4'b1111, 32'h0000_1000, 1, 4'b0000, 0, "mem wr inv");

    // overlapping windows: lowest index wins (R5)
    base2 = 32'h0000_2040;
    doTx(4'b0010, 32'h0000_2041, 0, 4'b1101, 0, "overlap win1 win2");
    base1 = 32'h0000_1000;
    doTx(4'b0011, 32'h0000_1002, 0, 4'b1011, 1, "overlap win0 win1");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R6 all transactions seen", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule